// File: doc/BRIEF.md
# Staged-Write Host Register File

This block is the host-facing register file of a three-channel line-interface device. The host drives an address, write data, a chip select and separate write and read strobes. Every write first loads a staging register, which the host can read back to confirm what it last wrote. The same write is copied into the addressed register only once the write strobe has been held for a minimum number of clocks. A strobe that is too short updates the staging register and nothing else.

The file holds a common group and three identical per-channel groups. The common group has two control registers and an interrupt mask. Each channel group has a transmit control register, a receive control register and a read-only status register. Each channel delivers a one-clock frame tick together with a new status value. The status value is latched only on that tick, so the host never sees a value that is half-updated. The tick also sets the channel's bit in the interrupt request register, and a read of that register clears it.

The host bus is strobe-timed and has no valid/ready handshake. The host must hold address and data stable while a strobe is active. Read data is registered and is never back-pressured. The frame ticks are plain pulses that are always accepted.

Top module: `hreg_shadow_regfile`

## Requirements
- R1: After reset, all control registers, the mask, the staging register, the status registers and the interrupt request bits are zero, and `irq` and `host_rdata` are 0.
- R2: Every clock edge that samples `host_cs` and `host_wr` both high loads `host_wdata` into the staging register. A read of address 0x3B returns the last value written, whatever address that write targeted.
- R3: The addressed register is loaded only at the edge that samples the write strobe active for the MIN_WR_CLKS-th consecutive time (default 3). A strobe of fewer edges leaves every target unchanged.
- R4: A write to 0x3B changes only the staging register.
- R5: The address map is as follows. Common control A is at 0x00 and common control B at 0x01, and both drive ports. The irq mask is at 0x1E, in bits [2:0]. Channel c (0..2) has its registers at base 0x40+0x10*c: transmit control at +0, receive control at +1, read-only status at +2. Channel c's control values appear on byte c of `tx_ctrl` and `rx_ctrl`.
- R6: A channel's status register loads `status_in` byte c only at an edge where `frame_tick[c]` is 1. At all other edges it holds.
- R7: Bit c of the interrupt request register at 0x1F sets on `frame_tick[c]`. A read of 0x1F returns the bits in [2:0] with zeros above, as they were before the read's first edge, and clears them at that edge. A tick at that same edge wins over the clear.
- R8: `irq` is high exactly when some interrupt request bit is set and its mask bit is 1.
- R9: Reads of unimplemented addresses return 0. Writes to unimplemented addresses, to the status registers or to 0x1F change only the staging register.
- R10: Read data is captured at the first edge of a read strobe and held while the strobe stays active. `host_rdata` is 0 after any edge where no read strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Chip select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 8 | Register address |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Registered read data |
| frame_tick | input | NCH | One-clock frame event per channel |
| status_in | input | NCH*DW | New status value per channel, byte c for channel c |
| ctrl_a | output | DW | Common control A |
| ctrl_b | output | DW | Common control B |
| tx_ctrl | output | NCH*DW | Transmit control per channel |
| rx_ctrl | output | NCH*DW | Receive control per channel |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. No control output changes before the write strobe has run its full minimum length. The staging register moves only under a write strobe. Status values hold between frame ticks. An interrupt request bit never sets without its tick. `irq` rises only after a tick or a write, and read data returns to zero once the strobe drops. Some behaviours need the bench's scenarios to show them: the address decode of each group, the readback of the staging register after writes to different targets, the clear-on-read snapshot with a colliding tick, masking, and whether writes to read-only or unmapped addresses have any effect.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_CTRL_A = 8'h00;
  localparam logic [AW-1:0] A_CTRL_B = 8'h01;
  localparam logic [AW-1:0] A_MASK   = 8'h1E;
  localparam logic [AW-1:0] A_IRR    = 8'h1F;
  localparam logic [AW-1:0] A_STAGE  = 8'h3B;
  localparam int CH_BASE   = 'h40;
  localparam int CH_STRIDE = 'h10;
  localparam int OFS_TX    = 0;
  localparam int OFS_RX    = 1;
  localparam int OFS_STAT  = 2;

  function automatic logic [AW-1:0] chan_addr(input int ch, input int ofs);
    return AW'(CH_BASE + CH_STRIDE * ch + ofs);
  endfunction
endpackage

// File: rtl/hreg_wr_gate.sv
module hreg_wr_gate
  import hreg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int MIN_WR_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] staging,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);
  localparam int CW = $clog2(MIN_WR_CLKS + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_WR_CLKS);

  logic          active;
  logic [CW-1:0] run_q;

  assign active = cs && wr;

  // Commit happens on the edge that completes the minimum strobe run
  assign commit      = active && (run_q == CMAX - 1'b1);
  assign commit_addr = addr;
  assign commit_data = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      staging <= '0;
    end else begin
      if (active) begin
        staging <= wdata;
        run_q   <= (run_q == CMAX) ? CMAX : run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/hreg_chan_group.sv
module hreg_chan_group
  import hreg_pkg::*;
#(
  parameter int DW = 8,
  parameter int CH = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] commit_addr,
  input  logic [DW-1:0] commit_data,
  input  logic          tick,
  input  logic [DW-1:0] status_new,
  input  logic          irr_clr,
  output logic [DW-1:0] tx_ctrl,
  output logic [DW-1:0] rx_ctrl,
  output logic [DW-1:0] status_q,
  output logic          irr_bit
);
  localparam logic [AW-1:0] A_TX = chan_addr(CH, OFS_TX);
  localparam logic [AW-1:0] A_RX = chan_addr(CH, OFS_RX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ctrl  <= '0;
      rx_ctrl  <= '0;
      status_q <= '0;
      irr_bit  <= 1'b0;
    end else begin
      if (commit && commit_addr == A_TX) tx_ctrl <= commit_data;
      if (commit && commit_addr == A_RX) rx_ctrl <= commit_data;
      if (tick) status_q <= status_new;
      // a fresh frame event outranks the host's clear
      if (tick)         irr_bit <= 1'b1;
      else if (irr_clr) irr_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/hreg_read_port.sv
module hreg_read_port
  import hreg_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     ctrl_a,
  input  logic [DW-1:0]     ctrl_b,
  input  logic [NCH-1:0]    mask,
  input  logic [NCH-1:0]    irr,
  input  logic [DW-1:0]     staging,
  input  logic [NCH*DW-1:0] tx_flat,
  input  logic [NCH*DW-1:0] rx_flat,
  input  logic [NCH*DW-1:0] stat_flat,
  output logic              irr_clr,
  output logic [DW-1:0]     rdata
);
  logic          active, active_q, first;
  logic [DW-1:0] sel;

  assign active  = cs && rd;
  assign first   = active && !active_q;
  assign irr_clr = first && (addr == A_IRR);

  always_comb begin
    sel = '0;
    unique case (addr)
      A_CTRL_A: sel = ctrl_a;
      A_CTRL_B: sel = ctrl_b;
      A_MASK:   sel[NCH-1:0] = mask;
      A_IRR:    sel[NCH-1:0] = irr;
      A_STAGE:  sel = staging;
      default:  sel = '0;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (addr == chan_addr(c, OFS_TX))   sel = tx_flat[c*DW +: DW];
      if (addr == chan_addr(c, OFS_RX))   sel = rx_flat[c*DW +: DW];
      if (addr == chan_addr(c, OFS_STAT)) sel = stat_flat[c*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rdata    <= '0;
    end else begin
      active_q <= active;
      if (first)        rdata <= sel;
      else if (!active) rdata <= '0;
    end
  end
endmodule

// File: rtl/hreg_shadow_regfile.sv
module hreg_shadow_regfile
  import hreg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NCH         = 3,
  parameter int MIN_WR_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [NCH-1:0]    frame_tick,
  input  logic [NCH*DW-1:0] status_in,
  output logic [DW-1:0]     ctrl_a,
  output logic [DW-1:0]     ctrl_b,
  output logic [NCH*DW-1:0] tx_ctrl,
  output logic [NCH*DW-1:0] rx_ctrl,
  output logic              irq
);
  logic [DW-1:0]     staging_q;
  logic              commit;
  logic [AW-1:0]     commit_addr;
  logic [DW-1:0]     commit_data;
  logic [NCH-1:0]    mask_q;
  logic [NCH-1:0]    irr_vec;
  logic [NCH*DW-1:0] stat_flat;
  logic              irr_clr;

  hreg_wr_gate #(.DW(DW), .MIN_WR_CLKS(MIN_WR_CLKS)) wr_gate_i (
    .clk(clk), .rst_n(rst_n), .cs(host_cs), .wr(host_wr),
    .addr(host_addr), .wdata(host_wdata), .staging(staging_q),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_a <= '0;
      ctrl_b <= '0;
      mask_q <= '0;
    end else if (commit) begin
      if (commit_addr == A_CTRL_A) ctrl_a <= commit_data;
      if (commit_addr == A_CTRL_B) ctrl_b <= commit_data;
      if (commit_addr == A_MASK)   mask_q <= commit_data[NCH-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    hreg_chan_group #(.DW(DW), .CH(c)) grp_i (
      .clk(clk), .rst_n(rst_n),
      .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
      .tick(frame_tick[c]), .status_new(status_in[c*DW +: DW]),
      .irr_clr(irr_clr),
      .tx_ctrl(tx_ctrl[c*DW +: DW]), .rx_ctrl(rx_ctrl[c*DW +: DW]),
      .status_q(stat_flat[c*DW +: DW]), .irr_bit(irr_vec[c])
    );
  end

  hreg_read_port #(.DW(DW), .NCH(NCH)) rd_port_i (
    .clk(clk), .rst_n(rst_n), .cs(host_cs), .rd(host_rd), .addr(host_addr),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .mask(mask_q), .irr(irr_vec),
    .staging(staging_q), .tx_flat(tx_ctrl), .rx_flat(rx_ctrl),
    .stat_flat(stat_flat), .irr_clr(irr_clr), .rdata(host_rdata)
  );

  assign irq = |(irr_vec & mask_q);
endmodule

// File: rtl/hreg_shadow_chk.sv
module hreg_shadow_chk #(
  parameter int DW          = 8,
  parameter int NCH         = 3,
  parameter int MIN_WR_CLKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cs,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DW-1:0]     host_rdata,
  input logic [NCH-1:0]    frame_tick,
  input logic [DW-1:0]     ctrl_a,
  input logic [DW-1:0]     ctrl_b,
  input logic [NCH*DW-1:0] tx_ctrl,
  input logic [NCH*DW-1:0] rx_ctrl,
  input logic              irq,
  input logic [DW-1:0]     staging_q,
  input logic [NCH-1:0]    irr_vec,
  input logic [NCH*DW-1:0] stat_flat
);
  localparam int CW = $clog2(MIN_WR_CLKS + 1);
  logic [CW-1:0] wr_run;
  logic [2*DW+2*NCH*DW-1:0] ctl_all;
  assign ctl_all = {ctrl_a, ctrl_b, tx_ctrl, rx_ctrl};

  always_ff @(posedge clk) begin
    if (!rst_n) wr_run <= '0;
    else if (host_cs && host_wr)
      wr_run <= (wr_run == CW'(MIN_WR_CLKS)) ? wr_run : wr_run + 1'b1;
    else wr_run <= '0;
  end

  // R3
  min_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ctl_all) |-> (wr_run >= CW'(MIN_WR_CLKS)));
  // R2
  staging_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_cs && host_wr) |=> $stable(staging_q));
  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick == '0) |=> $stable(stat_flat));
  // R7
  irr_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_vec & ~$past(irr_vec) & ~$past(frame_tick)) == '0));
  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|frame_tick) || $past(host_cs && host_wr)));
  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_cs && host_rd) |=> (host_rdata == '0));
endmodule

bind hreg_shadow_regfile hreg_shadow_chk #(.DW(DW), .NCH(NCH), .MIN_WR_CLKS(MIN_WR_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
  .host_rdata(host_rdata), .frame_tick(frame_tick), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
  .tx_ctrl(tx_ctrl), .rx_ctrl(rx_ctrl), .irq(irq), .staging_q(staging_q),
  .irr_vec(irr_vec), .stat_flat(stat_flat)
);

// File: tb/hreg_shadow_regfile_tb.sv
module hreg_shadow_regfile_tb_top;
  localparam int DW = 8;
  localparam int NCH = 3;
  localparam int MINW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cs = 0, host_wr = 0, host_rd = 0;
  logic [7:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic [NCH-1:0] frame_tick = '0;
  logic [NCH*DW-1:0] status_in = '0;
  logic [DW-1:0] ctrl_a, ctrl_b;
  logic [NCH*DW-1:0] tx_ctrl, rx_ctrl;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hreg_shadow_regfile #(.DW(DW), .NCH(NCH), .MIN_WR_CLKS(MINW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_tick(frame_tick), .status_in(status_in), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .tx_ctrl(tx_ctrl), .rx_ctrl(rx_ctrl), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d, input int n);
    @(negedge clk);
    host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
    repeat (n) @(posedge clk);
    @(negedge clk);
    host_cs = 0; host_wr = 0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = host_rdata;
    host_cs = 0; host_rd = 0;
  endtask

  task automatic frame(input int ch, input logic [7:0] v);
    @(negedge clk);
    status_in[ch*DW +: DW] = v;
    frame_tick[ch] = 1'b1;
    @(negedge clk);
    frame_tick = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 ctrl_a", ctrl_a, 0);
    check("R1 tx_ctrl", tx_ctrl, 0);
    check("R1 irq", irq, 0);
    check("R1 rdata", host_rdata, 0);
    host_read(8'h3B, d); check("R1 staging", d, 0);
    host_read(8'h1F, d); check("R1 irr", d, 0);
    host_read(8'h42, d); check("R1 status", d, 0);
  endtask

  task automatic t_staging_readback();
    logic [7:0] d;
    host_write(8'h00, 8'hA5, MINW);
    check("R5 ctrl_a", ctrl_a, 8'hA5);
    host_read(8'h3B, d); check("R2 staging after ctrl_a", d, 8'hA5);
    host_write(8'h50, 8'h3C, MINW);
    check("R5 tx ch1", tx_ctrl[15:8], 8'h3C);
    host_read(8'h3B, d); check("R2 staging after tx ch1", d, 8'h3C);
    @(negedge clk); check("R10 rdata idle", host_rdata, 0);
  endtask

  task automatic t_short_strobe();
    logic [7:0] d;
    host_write(8'h01, 8'h77, MINW - 1);
    check("R3 short strobe", ctrl_b, 0);
    host_read(8'h3B, d); check("R2 staging short", d, 8'h77);
    host_write(8'h01, 8'h66, 1);
    check("R3 one-edge strobe", ctrl_b, 0);
    host_write(8'h01, 8'h77, MINW + 2);
    check("R3 long strobe", ctrl_b, 8'h77);
  endtask

  task automatic t_stage_addr();
    logic [7:0] d;
    host_write(8'h3B, 8'h99, MINW);
    check("R4 ctrl_a", ctrl_a, 8'hA5);
    check("R4 ctrl_b", ctrl_b, 8'h77);
    check("R4 tx", tx_ctrl, 24'h003C00);
    check("R4 rx", rx_ctrl, 0);
    host_read(8'h3B, d); check("R4 staging", d, 8'h99);
  endtask

  task automatic t_map();
    logic [7:0] d;
    host_write(8'h61, 8'h42, MINW);
    check("R5 rx ch2", rx_ctrl, 24'h420000);
    host_read(8'h61, d); check("R5 read rx ch2", d, 8'h42);
    host_read(8'h41, d); check("R5 read rx ch0", d, 0);
    host_read(8'h50, d); check("R5 read tx ch1", d, 8'h3C);
    host_write(8'h1E, 8'hFF, MINW);
    host_read(8'h1E, d); check("R5 mask width", d, 8'h07);
    host_write(8'h1E, 8'h00, MINW);
  endtask

  task automatic t_status();
    logic [7:0] d;
    frame(0, 8'h5A);
    host_read(8'h42, d); check("R6 latched", d, 8'h5A);
    @(negedge clk); status_in[7:0] = 8'h11;
    repeat (3) @(negedge clk);
    host_read(8'h42, d); check("R6 no tick hold", d, 8'h5A);
    host_write(8'h42, 8'hEE, MINW);
    host_read(8'h42, d); check("R9 status read-only", d, 8'h5A);
    frame(2, 8'hC3);
    host_read(8'h62, d); check("R6 ch2 latched", d, 8'hC3);
    host_read(8'h1F, d);
  endtask

  task automatic t_irr();
    logic [7:0] d;
    frame(1, 8'h01);
    check("R8 masked", irq, 0);
    host_read(8'h1F, d); check("R7 ch1 bit", d, 8'h02);
    host_read(8'h1F, d); check("R7 cleared", d, 0);
    frame(0, 8'h02);
    frame(2, 8'h03);
    host_read(8'h1F, d); check("R7 two bits", d, 8'h05);
    host_write(8'h1F, 8'h07, MINW);
    host_read(8'h1F, d); check("R9 irr not writable", d, 0);
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_addr = 8'h1F; frame_tick[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    d = host_rdata; host_cs = 0; host_rd = 0; frame_tick = '0;
    check("R7 snapshot before tick", d, 0);
    host_read(8'h1F, d); check("R7 tick wins over clear", d, 8'h01);
  endtask

  task automatic t_irq_mask();
    logic [7:0] d;
    host_write(8'h1E, 8'h04, MINW);
    frame(1, 8'h00);
    @(negedge clk); check("R8 unmasked bit absent", irq, 0);
    frame(2, 8'h00);
    @(negedge clk); check("R8 irq high", irq, 1);
    host_read(8'h1F, d); check("R7 read both", d, 8'h06);
    @(negedge clk); check("R8 irq cleared", irq, 0);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    host_write(8'h30, 8'hDE, MINW);
    host_read(8'h30, d); check("R9 unimpl read", d, 0);
    host_read(8'h3B, d); check("R9 staging updated", d, 8'hDE);
    check("R9 ctrl_a kept", ctrl_a, 8'hA5);
    check("R9 rx kept", rx_ctrl, 24'h420000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_staging_readback();
    t_short_strobe();
    t_stage_addr();
    t_map();
    t_status();
    t_irr();
    t_irq_mask();
    t_unimpl();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule